// File: doc/BRIEF.md
# Configuration Image Checksum Engine

This block holds a 128-byte configuration image for a serial non-volatile memory and walks it as 64 little-endian 16-bit words, one word per clock. It runs three jobs. One writes a checksum word into the last word of an image. One checks an image that already carries its checksum. One rebuilds the factory default image and seals it. The serial memory device and its bit-level protocol stay outside. Software or a loader fills and reads the image through a byte-wide port, then starts a job with a mode code.

The seal rule is as follows. Word k is byte 2k plus 256 times byte 2k+1. The checksum is 0x1234 minus the 16-bit wrapping sum of words 0 to 62. It lands in word 63, so a sealed image sums over all 64 words to 0x1234. A job raises `busy` for exactly 64 cycles. It then pulses `done` for one cycle with `valid` and `result`, and these two stay put until the next accepted start.

Top module: `cfg_eeprom_chk`

## Requirements
- R1: While reset is high and after it is released, `busy`, `done` and `valid` are 0 and `result` is 0x0000.
- R2: In mode 2'b00 (seal), word k is byte 2k + (byte 2k+1 << 8), and `result` is 0x1234 minus the sum of words 0..62, taken modulo 2^16.
- R3: A seal job writes the checksum low byte to address 126 and the high byte to address 127, and reports `valid` = 1.
- R4: In mode 2'b01 (check), the block sums all 64 words. `result` is that sum, and `valid` is 1 exactly when the sum equals 0x1234. The image is left unchanged.
- R5: In mode 2'b10 (default), even bytes 0..30 become 0x57 and odd bytes 1..31 become 0x00. Byte 64 becomes 0x07, byte 65 0x0F, byte 67 0x04, and byte 68 0x07 (option bits 0, 1 and 2 set, bit 3 clear). Every other byte up to 125 is 0. Bytes 126/127 receive the seal of that image, so `result` is 0xF9B6.
- R6: `start` is sampled on a rising edge while idle. `busy` is then high for exactly 64 cycles, one word per cycle. `done` is high for the single cycle after the last word, which is the first cycle with `busy` low.
- R7: A start with mode 2'b11 is not accepted. A start while `busy` is high is ignored, and the running job finishes with its own mode and result.
- R8: `host_rdata` shows the byte at `host_addr` without a clock. A host write while `busy` is high has no effect.
- R9: `result` and `valid` hold their values from `done` until the next accepted start, which clears them to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| host_addr | input | 7 | Byte address into the image |
| host_wdata | input | 8 | Byte to write |
| host_we | input | 1 | Write strobe, ignored while busy |
| host_rdata | output | 8 | Byte at host_addr, combinational |
| start | input | 1 | Begin a job when idle |
| mode | input | 2 | 00 seal, 01 check, 10 default fill, 11 rejected |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| valid | output | 1 | Job outcome good (check passed, or seal written) |
| result | output | 16 | Checksum written, or sum found in check mode |

## Verification
The hardest situations to reach from the ports are those that happen inside a running job. One is a host write that must not land. The other is a second start that must not disturb the running job. The bench injects both on the tenth busy cycle of a job. It then reads the target byte back and compares the job's result against a model that ignores the injected stimulus. A check image sealed with a checksum off by one in its low byte proves that `valid` really depends on the sum.

// File: rtl/cfgchk_pkg.sv
package cfgchk_pkg;
    localparam int IMG_BYTES = 128;
    localparam int WORDS     = IMG_BYTES / 2;
    localparam int ADDR_W    = $clog2(IMG_BYTES);
    localparam int IDX_W     = $clog2(WORDS);
    localparam int SUM_W     = 16;

    localparam logic [SUM_W-1:0] SEAL_TARGET = 16'h1234;

    // default image contents
    localparam int          PAT_BYTES   = 32;
    localparam logic [7:0]  PAT_EVEN    = 8'h57;
    localparam int          AT_HOST_ID  = 64;
    localparam int          AT_XFER_CFG = 65;
    localparam int          AT_QDEPTH   = 67;
    localparam int          AT_OPTS     = 68;
    localparam logic [7:0]  HOST_ID     = 8'd7;
    localparam logic [7:0]  XFER_CFG    = 8'h0F;
    localparam logic [7:0]  QDEPTH      = 8'h04;
    localparam logic [7:0]  OPT_KEY_PROMPT = 8'h01;
    localparam logic [7:0]  OPT_OPT_BOOT   = 8'h02;
    localparam logic [7:0]  OPT_BIOS_DISK  = 8'h04;
    localparam logic [7:0]  OPTS_DEFAULT   = OPT_KEY_PROMPT | OPT_OPT_BOOT | OPT_BIOS_DISK;

    typedef enum logic [1:0] {
        OP_SEAL  = 2'b00,
        OP_CHECK = 2'b01,
        OP_FILL  = 2'b10,
        OP_RSVD  = 2'b11
    } op_e;

    typedef struct packed {
        logic [SUM_W-1:0] value;
        logic             ok;
    } result_t;

    function automatic logic [7:0] dflt_byte(input logic [ADDR_W-1:0] a);
        logic [7:0] b;
        b = 8'h00;
        if (int'(a) < PAT_BYTES) b = a[0] ? 8'h00 : PAT_EVEN;
        else if (int'(a) == AT_HOST_ID)  b = HOST_ID;
        else if (int'(a) == AT_XFER_CFG) b = XFER_CFG;
        else if (int'(a) == AT_QDEPTH)   b = QDEPTH;
        else if (int'(a) == AT_OPTS)     b = OPTS_DEFAULT;
        return b;
    endfunction

    function automatic logic [SUM_W-1:0] dflt_word(input logic [IDX_W-1:0] w);
        return {dflt_byte({w, 1'b1}), dflt_byte({w, 1'b0})};
    endfunction
endpackage

// File: rtl/cfgchk_image_ram.sv
module cfgchk_image_ram
    import cfgchk_pkg::*;
(
    input  logic              clk,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              eng_we,
    input  logic [IDX_W-1:0]  eng_idx,
    input  logic [SUM_W-1:0]  eng_wword,
    output logic [SUM_W-1:0]  eng_rword
);
    logic [7:0] lane_rd [2];

    // two byte lanes: lane 0 holds even addresses, lane 1 odd addresses
    for (genvar b = 0; b < 2; b++) begin : g_lane
        logic [7:0] mem [WORDS];
        logic       host_hit;

        assign host_hit = host_we && (int'(host_addr[0]) == b);

        always_ff @(posedge clk) begin
            if (eng_we)
                mem[eng_idx] <= eng_wword[8*b +: 8];
            else if (host_hit)
                mem[host_addr[ADDR_W-1:1]] <= host_wdata;
        end

        assign eng_rword[8*b +: 8] = mem[eng_idx];
        assign lane_rd[b]          = mem[host_addr[ADDR_W-1:1]];
    end

    assign host_rdata = lane_rd[host_addr[0]];
endmodule

// File: rtl/cfgchk_seq.sv
module cfgchk_seq
    import cfgchk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  op_e              op_in,
    output logic             busy,
    output logic [IDX_W-1:0] idx,
    output logic             last,
    output op_e              op,
    output logic             accept,
    output logic             done
);
    typedef enum logic {S_IDLE, S_RUN} st_e;
    st_e st;

    assign busy   = (st == S_RUN);
    assign accept = start && (st == S_IDLE) && (op_in != OP_RSVD);
    assign last   = busy && (idx == IDX_W'(WORDS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= S_IDLE;
            idx  <= '0;
            op   <= OP_SEAL;
            done <= 1'b0;
        end else begin
            done <= last;
            if (accept) begin
                st  <= S_RUN;
                idx <= '0;
                op  <= op_in;
            end else if (busy) begin
                idx <= idx + 1'b1;
                if (last) st <= S_IDLE;
            end
        end
    end
endmodule

// File: rtl/cfgchk_accum.sv
module cfgchk_accum
    import cfgchk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    input  logic             last,
    input  op_e              op,
    input  logic [SUM_W-1:0] word,
    output logic [SUM_W-1:0] seal_word,
    output result_t          res
);
    logic [SUM_W-1:0] acc;
    logic [SUM_W-1:0] full_sum;

    assign seal_word = SEAL_TARGET - acc;
    assign full_sum  = acc + word;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
            res <= '0;
        end else if (clear) begin
            acc <= '0;
            res <= '0;
        end else if (step) begin
            if (!last) begin
                acc <= full_sum;
            end else if (op == OP_CHECK) begin
                res.value <= full_sum;
                res.ok    <= (full_sum == SEAL_TARGET);
            end else begin
                res.value <= seal_word;
                res.ok    <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/cfg_eeprom_chk.sv
module cfg_eeprom_chk
    import cfgchk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [6:0]  host_addr,
    input  logic [7:0]  host_wdata,
    input  logic        host_we,
    output logic [7:0]  host_rdata,
    input  logic        start,
    input  logic [1:0]  mode,
    output logic        busy,
    output logic        done,
    output logic        valid,
    output logic [15:0] result
);
    logic             run;
    logic [IDX_W-1:0] idx;
    logic             last;
    logic             accept;
    op_e              op;
    logic [SUM_W-1:0] ram_word;
    logic [SUM_W-1:0] def_word;
    logic [SUM_W-1:0] sum_in;
    logic [SUM_W-1:0] seal_word;
    logic             eng_we;
    logic [SUM_W-1:0] eng_wword;
    result_t          res;

    cfgchk_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .op_in  (op_e'(mode)),
        .busy   (run),
        .idx    (idx),
        .last   (last),
        .op     (op),
        .accept (accept),
        .done   (done)
    );

    assign def_word  = dflt_word(idx);
    assign sum_in    = (op == OP_FILL) ? def_word : ram_word;
    assign eng_we    = run && (op != OP_CHECK) && (last || op == OP_FILL);
    assign eng_wword = last ? seal_word : def_word;

    cfgchk_image_ram u_ram (
        .clk        (clk),
        .host_we    (host_we && !run),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .eng_we     (eng_we),
        .eng_idx    (idx),
        .eng_wword  (eng_wword),
        .eng_rword  (ram_word)
    );

    cfgchk_accum u_acc (
        .clk       (clk),
        .rst       (rst),
        .clear     (accept),
        .step      (run),
        .last      (last),
        .op        (op),
        .word      (sum_in),
        .seal_word (seal_word),
        .res       (res)
    );

    assign busy   = run;
    assign valid  = res.ok;
    assign result = res.value;
endmodule

// File: rtl/cfg_eeprom_chk_chk.sv
module cfg_eeprom_chk_chk
    import cfgchk_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic [1:0]  mode,
    input logic        busy,
    input logic        done,
    input logic        valid,
    input logic [15:0] result
);
    logic [IDX_W+1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst)       run_cnt <= '0;
        else if (busy) run_cnt <= run_cnt + 1'b1;
        else           run_cnt <= '0;
    end

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_done_at_end_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);
    assert_run_length_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_cnt == (IDX_W+2)'(WORDS)));
    assert_start_taken_R6: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && mode != 2'b11) |=> busy);
    assert_rsvd_reject_R7: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && mode == 2'b11) |=> !busy);
    assert_result_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy && !done) |-> ($stable(result) && $stable(valid)));
endmodule

bind cfg_eeprom_chk cfg_eeprom_chk_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .mode   (mode),
    .busy   (busy),
    .done   (done),
    .valid  (valid),
    .result (result)
);

// File: tb/cfg_eeprom_chk_bench.sv
`timescale 1ns/1ps
module cfg_eeprom_chk_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_we = 1'b0;
    logic [7:0]  host_rdata;
    logic        start = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        busy, done, valid;
    logic [15:0] result;

    int total = 0;
    int fails = 0;
    int cyc = 0;
    logic [7:0] img [128];

    cfg_eeprom_chk u_cfg_eeprom_chk (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_we(host_we), .host_rdata(host_rdata), .start(start), .mode(mode),
        .busy(busy), .done(done), .valid(valid), .result(result)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++; fails++;
            $display("FAIL R6 watchdog actual=%0d expected<150000", cyc);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    // vector table: pattern byte i = mul*i + seed
    // seal: 0 raw, 1 correct checksum, 2 checksum low byte + 1
    typedef struct packed {
        logic [7:0] mul;
        logic [7:0] seed;
        logic [1:0] op;
        logic [1:0] seal;
        logic       exp_ok;
    } vec_t;
    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{8'd3,   8'd1,   2'b00, 2'd0, 1'b1},
        '{8'd0,   8'd0,   2'b00, 2'd0, 1'b1},
        '{8'd251, 8'hC4,  2'b00, 2'd0, 1'b1},
        '{8'd5,   8'd9,   2'b01, 2'd1, 1'b1},
        '{8'd5,   8'd9,   2'b01, 2'd2, 1'b0},
        '{8'd0,   8'hFF,  2'b01, 2'd1, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] sum_words(input int n);
        logic [15:0] s = '0;
        for (int k = 0; k < n; k++) s = s + {img[2*k+1], img[2*k]};
        return s;
    endfunction

    function automatic logic [7:0] def_b(input int i);
        if (i < 32) return (i % 2 == 0) ? 8'h57 : 8'h00;
        if (i == 64) return 8'h07;
        if (i == 65) return 8'h0F;
        if (i == 67) return 8'h04;
        if (i == 68) return 8'h07;
        return 8'h00;
    endfunction

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        host_addr = 7'(a); host_wdata = d; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        @(negedge clk);
        host_addr = 7'(a);
        #1 d = host_rdata;
    endtask

    task automatic load_img();
        for (int i = 0; i < 128; i++) wr(i, img[i]);
    endtask

    // inj: 0 none, 1 host write to byte 5 on busy cycle 10, 2 second start
    task automatic run_op(input logic [1:0] m, input int inj, input string tag);
        int n = 0;
        @(negedge clk);
        start = 1'b1; mode = m;
        @(negedge clk);
        start = 1'b0;
        while (busy && n < 200) begin
            n++;
            if (n == 10 && inj == 1) begin
                host_addr = 7'd5; host_wdata = ~img[5]; host_we = 1'b1;
            end else if (n == 10 && inj == 2) begin
                start = 1'b1; mode = 2'b01;
            end else begin
                host_we = 1'b0; start = 1'b0;
            end
            @(negedge clk);
        end
        host_we = 1'b0; start = 1'b0;
        chk({tag, " R6 busy cycles"}, n, 64);
        chk({tag, " R6 done after last word"}, done, 1);
        @(negedge clk);
        chk({tag, " R6 done one cycle"}, done, 0);
    endtask

    initial begin
        logic [15:0] s;
        logic [15:0] c;
        logic [7:0]  b;
        logic [15:0] keep_res;
        logic        keep_val;
        int          bad;

        repeat (3) @(negedge clk);
        chk("R1 busy in reset", busy, 0);
        chk("R1 done in reset", done, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy after reset", busy, 0);
        chk("R1 valid after reset", valid, 0);
        chk("R1 result after reset", result, 0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            for (int i = 0; i < 128; i++) img[i] = 8'(VECS[v].mul * i + VECS[v].seed);
            if (VECS[v].seal != 2'd0) begin
                c = 16'h1234 - sum_words(63);
                img[126] = c[7:0] + ((VECS[v].seal == 2'd2) ? 8'd1 : 8'd0);
                img[127] = c[15:8];
            end
            load_img();
            run_op(VECS[v].op, 0, "table");
            if (VECS[v].op == 2'b00) begin
                c = 16'h1234 - sum_words(63);
                chk("R2 seal result", result, c);
                chk("R3 seal valid", valid, 1);
                rd(126, b); chk("R3 low byte at 126", b, c[7:0]);
                rd(127, b); chk("R3 high byte at 127", b, c[15:8]);
            end else begin
                chk("R4 check sum", result, sum_words(64));
                chk("R4 check valid", valid, VECS[v].exp_ok);
                rd(126, b); chk("R4 image untouched", b, img[126]);
            end
        end

        // seal then check the same image
        run_op(2'b01, 0, "chain");
        chk("R4 sealed image checks good", valid, 1);

        // default fill
        for (int i = 0; i < 128; i++) img[i] = 8'hA5;
        load_img();
        run_op(2'b10, 0, "fill");
        for (int i = 0; i < 126; i++) img[i] = def_b(i);
        c = 16'h1234 - sum_words(63);   // 0xF9B6
        img[126] = c[7:0]; img[127] = c[15:8];
        chk("R5 fill result", result, 16'hF9B6);
        chk("R5 fill model agrees", c, 16'hF9B6);
        bad = 0;
        for (int i = 0; i < 128; i++) begin
            rd(i, b);
            if (b !== img[i]) bad++;
        end
        chk("R5 default image bytes mismatched", bad, 0);
        run_op(2'b01, 0, "fill-check");
        chk("R5 default image checks good", valid, 1);

        // R9 hold
        keep_res = result; keep_val = valid;
        repeat (10) @(negedge clk);
        chk("R9 result held", result, keep_res);
        chk("R9 valid held", valid, keep_val);

        // R7 reserved mode
        @(negedge clk);
        start = 1'b1; mode = 2'b11;
        @(negedge clk);
        start = 1'b0;
        chk("R7 reserved mode not accepted", busy, 0);
        chk("R9 result after rejected start", result, keep_res);

        // R7 start while busy: seal job must finish as seal
        for (int i = 0; i < 128; i++) img[i] = 8'(7 * i + 3);
        load_img();
        run_op(2'b00, 2, "restart");
        c = 16'h1234 - sum_words(63);
        chk("R7 start while busy ignored", result, c);
        rd(127, b); chk("R7 seal written despite restart", b, c[15:8]);

        // R8 host write while busy
        img[126] = c[7:0]; img[127] = c[15:8];
        run_op(2'b01, 1, "hostwr");
        rd(5, b); chk("R8 busy write dropped", b, img[5]);
        chk("R8 check unaffected", valid, 1);
        chk("R8 check sum", result, 16'h1234);

        // R9 clear on accepted start
        @(negedge clk);
        start = 1'b1; mode = 2'b01;
        @(negedge clk);
        start = 1'b0;
        chk("R9 cleared by start result", result, 0);
        chk("R9 cleared by start valid", valid, 0);
        while (busy) @(negedge clk);
        @(negedge clk);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule